// File: doc/BRIEF.md
# Trap Vector and Mask Controller

This block decides which pending exception event the processor services next and where the handler for it lives. It captures single-cycle request pulses from up to 48 trap sources, from an architectural reset request, and from an extended-operation (Xop) request that carries an 8-bit opcode. It holds each request as pending until it is serviced. On each service it emits a one-cycle take strobe with the handler's word address, the event code, and flags. The flags say whether the event was an Xop and whether the transfer is a call (a return context is saved) or a plain jump.

Handlers sit in two regions with slots four words apart. The Xop region starts at word address 0x40000 and has 256 slots. The general trap region follows it at 0x40400, with one slot per trap index. A trap-enable bit gates the eight maskable indices 8 to 15. Servicing any index below 16 clears the bit. Software can rewrite the bit through a write strobe.

Control is a two-state machine. `ST_IDLE` moves to `ST_TAKE` on the transition *event_picked*, when an eligible event exists. `ST_TAKE` moves back to `ST_IDLE` on the unconditional transition *strobe_done*. An event is picked only in `ST_IDLE`, so at most one event is serviced every two cycles.

Top module: `trapvec_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `take_o`, `is_xop_o`, `is_call_o` and `trap_en_o` are 0 and `vector_o` and `index_o` are 0.
- R2: For a serviced trap with index X, `vector_o` equals 0x40400 + 4·X, `index_o` equals X and `is_xop_o` is 0.
- R3: For a serviced Xop with opcode P, `vector_o` equals 0x40000 + 4·P, `index_o` equals P and `is_xop_o` is 1.
- R4: Among eligible pending events, index 7 (reset) is served first. After it, the lowest pending trap index is served. An Xop is served only when no eligible trap is pending.
- R5: Indices 8 to 15 are not served while `trap_en_o` is 0. They stay pending and are served once the bit is set again. All other indices ignore the bit.
- R6: Serving any trap with index below 16 makes `trap_en_o` 0 in the take cycle. Serving a trap with index 16 or above, or an Xop, leaves it unchanged.
- R7: `is_call_o` is 0 when index 7 is served and 1 for every other trap and for every Xop.
- R8: A request pulse sampled at rising edge k, with the block idle and the event chosen, gives `take_o` high for exactly one cycle after edge k+1. The served request is cleared at that edge. A request line sampled at that same edge sets the request pending again.
- R9: `en_wr` sampled high loads `en_wdata` into `trap_en_o` at that edge. If an index below 16 is served at the same edge, the clear wins.
- R10: An `xop_req` sampled while an earlier Xop is still pending and not being served at that edge is ignored, and the earlier opcode is kept.
- R11: `reset_req` and `trap_req[7]` both raise the reset event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's state |
| trap_req | input | 48 | One-cycle request pulses, bit X for trap index X |
| reset_req | input | 1 | Architectural reset request (index 7) |
| xop_req | input | 1 | Extended-operation request pulse |
| xop_op | input | 8 | Opcode that goes with `xop_req` |
| en_wr | input | 1 | Software write strobe for the trap-enable bit |
| en_wdata | input | 1 | Value written to the trap-enable bit |
| take_o | output | 1 | One-cycle strobe: an event is being serviced |
| vector_o | output | 32 | Handler word address |
| index_o | output | 8 | Trap index, or the Xop opcode |
| is_xop_o | output | 1 | Serviced event is an Xop |
| is_call_o | output | 1 | 1 = call transfer, 0 = plain jump |
| trap_en_o | output | 1 | Current trap-enable bit |

## Verification
A request sampled at one rising edge is stored as pending at that edge. It can be picked at the next edge, so `take_o` and its address, code and flags appear one cycle after the request's sampling edge plus one. The enable bit changes at the take edge itself, so it is already updated during the strobe cycle. The bench keeps a behavioural model that steps once per rising edge, applying the same sampling order: pick, clear, enable update, then capture of new requests. Every output is compared 1 ns after each rising edge, with inputs changed only on falling edges. Directed sequences then check the logged order of services and their addresses against fixed values.

// File: rtl/trapvec_pkg.sv
package trapvec_pkg;
    parameter int unsigned ADDR_W     = 32;
    parameter int unsigned NUM_TRAPS  = 48;
    parameter int unsigned OP_W       = 8;
    parameter int unsigned SLOT_WORDS = 4;
    parameter int unsigned XOP_SLOTS  = 256;
    parameter int unsigned QUAD_SIZE  = 16;
    parameter int unsigned RESET_IDX  = 7;
    parameter int unsigned MASK_LO    = 8;
    parameter int unsigned MASK_HI    = 15;

    localparam int unsigned IDX_W    = $clog2(NUM_TRAPS);
    localparam int unsigned LOG_SLOT = $clog2(SLOT_WORDS);
    localparam logic [ADDR_W-1:0] XOP_BASE  = ADDR_W'(32'o1000000);
    localparam logic [ADDR_W-1:0] TRAP_BASE = XOP_BASE + ADDR_W'(XOP_SLOTS * SLOT_WORDS);

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_TAKE = 1'b1
    } tv_state_e;

    typedef struct packed {
        logic            valid;
        logic            is_xop;
        logic [OP_W-1:0] code;
    } tv_pick_t;
endpackage

// File: rtl/trapvec_pending.sv
module trapvec_pending
    import trapvec_pkg::*;
#(
    parameter int unsigned N_TRAPS = NUM_TRAPS,
    parameter int unsigned CODE_W  = OP_W,
    parameter int unsigned RST_IDX = RESET_IDX
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_TRAPS-1:0] trap_req,
    input  logic               reset_req,
    input  logic               xop_req,
    input  logic [CODE_W-1:0]  xop_op,
    input  logic [N_TRAPS-1:0] clr_trap,
    input  logic               clr_xop,
    output logic [N_TRAPS-1:0] pend,
    output logic               xop_pend,
    output logic [CODE_W-1:0]  xop_code
);
    localparam logic [N_TRAPS-1:0] RST_BIT = N_TRAPS'(1) << RST_IDX;

    logic [N_TRAPS-1:0] pend_d;
    logic               xop_free;

    always_comb begin
        pend_d = (pend & ~clr_trap) | trap_req | (reset_req ? RST_BIT : '0);
    end

    assign xop_free = !xop_pend || clr_xop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend     <= '0;
            xop_pend <= 1'b0;
            xop_code <= '0;
        end else begin
            pend <= pend_d;
            if (xop_req && xop_free) begin
                xop_pend <= 1'b1;
                xop_code <= xop_op;
            end else if (clr_xop) begin
                xop_pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/trapvec_arbiter.sv
module trapvec_arbiter
    import trapvec_pkg::*;
#(
    parameter int unsigned N_TRAPS = NUM_TRAPS,
    parameter int unsigned CODE_W  = OP_W,
    parameter int unsigned RST_IDX = RESET_IDX,
    parameter int unsigned MLO     = MASK_LO,
    parameter int unsigned MHI     = MASK_HI
) (
    input  logic [N_TRAPS-1:0] pend,
    input  logic               xop_pend,
    input  logic [CODE_W-1:0]  xop_code,
    input  logic               en,
    output tv_pick_t           pick,
    output logic [N_TRAPS-1:0] pick_trap,
    output logic               pick_xop
);
    localparam int unsigned SEL_W = $clog2(N_TRAPS);

    logic [N_TRAPS-1:0] elig;
    logic               trap_hit;
    logic [SEL_W-1:0]   trap_sel;

    for (genvar g = 0; g < N_TRAPS; g++) begin : g_elig
        if (g >= MLO && g <= MHI) begin : g_maskable
            assign elig[g] = pend[g] & en;
        end else begin : g_fixed
            assign elig[g] = pend[g];
        end
    end

    always_comb begin
        trap_hit = 1'b0;
        trap_sel = '0;
        for (int i = N_TRAPS - 1; i >= 0; i--) begin
            if (elig[i]) begin
                trap_hit = 1'b1;
                trap_sel = SEL_W'(i);
            end
        end
        if (elig[RST_IDX]) begin
            trap_sel = SEL_W'(RST_IDX);
        end
        pick.valid  = trap_hit || xop_pend;
        pick.is_xop = !trap_hit && xop_pend;
        pick.code   = trap_hit ? CODE_W'(trap_sel) : xop_code;
        pick_trap   = trap_hit ? (N_TRAPS'(1) << trap_sel) : '0;
        pick_xop    = pick.is_xop;
    end
endmodule

// File: rtl/trapvec_vector.sv
module trapvec_vector
    import trapvec_pkg::*;
#(
    parameter int unsigned AW      = ADDR_W,
    parameter int unsigned CODE_W  = OP_W,
    parameter int unsigned SHIFT   = LOG_SLOT,
    parameter int unsigned RST_IDX = RESET_IDX,
    parameter int unsigned QSIZE   = QUAD_SIZE,
    parameter logic [AW-1:0] X_BASE = XOP_BASE,
    parameter logic [AW-1:0] T_BASE = TRAP_BASE
) (
    input  logic              is_xop,
    input  logic [CODE_W-1:0] code,
    output logic [AW-1:0]     addr,
    output logic              is_call,
    output logic              quiets_en
);
    logic [AW-1:0] base;
    logic [AW-1:0] offset;

    always_comb begin
        base      = is_xop ? X_BASE : T_BASE;
        offset    = AW'(code) << SHIFT;
        addr      = base + offset;
        is_call   = is_xop || (code != CODE_W'(RST_IDX));
        quiets_en = !is_xop && (code < CODE_W'(QSIZE));
    end
endmodule

// File: rtl/trapvec_ctrl.sv
module trapvec_ctrl
    import trapvec_pkg::*;
#(
    parameter int unsigned AW      = ADDR_W,
    parameter int unsigned N_TRAPS = NUM_TRAPS,
    parameter int unsigned CODE_W  = OP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_TRAPS-1:0] trap_req,
    input  logic               reset_req,
    input  logic               xop_req,
    input  logic [CODE_W-1:0]  xop_op,
    input  logic               en_wr,
    input  logic               en_wdata,
    output logic               take_o,
    output logic [AW-1:0]      vector_o,
    output logic [CODE_W-1:0]  index_o,
    output logic               is_xop_o,
    output logic               is_call_o,
    output logic               trap_en_o
);
    tv_state_e          state, state_d;
    tv_pick_t           pick;
    logic [N_TRAPS-1:0] pend, pick_trap, clr_trap;
    logic               xop_pend, pick_xop, clr_xop;
    logic [CODE_W-1:0]  xop_code;
    logic [AW-1:0]      addr;
    logic               is_call, quiets_en;
    logic               do_take;

    trapvec_pending #(
        .N_TRAPS (N_TRAPS),
        .CODE_W  (CODE_W)
    ) u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .trap_req (trap_req),
        .reset_req(reset_req),
        .xop_req  (xop_req),
        .xop_op   (xop_op),
        .clr_trap (clr_trap),
        .clr_xop  (clr_xop),
        .pend     (pend),
        .xop_pend (xop_pend),
        .xop_code (xop_code)
    );

    trapvec_arbiter #(
        .N_TRAPS (N_TRAPS),
        .CODE_W  (CODE_W)
    ) u_arbiter (
        .pend     (pend),
        .xop_pend (xop_pend),
        .xop_code (xop_code),
        .en       (trap_en_o),
        .pick     (pick),
        .pick_trap(pick_trap),
        .pick_xop (pick_xop)
    );

    trapvec_vector #(
        .AW     (AW),
        .CODE_W (CODE_W)
    ) u_vector (
        .is_xop   (pick.is_xop),
        .code     (pick.code),
        .addr     (addr),
        .is_call  (is_call),
        .quiets_en(quiets_en)
    );

    assign do_take  = (state == ST_IDLE) && pick.valid;
    assign clr_trap = do_take ? pick_trap : '0;
    assign clr_xop  = do_take && pick_xop;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: if (pick.valid) state_d = ST_TAKE;
            ST_TAKE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_o    <= 1'b0;
            vector_o  <= '0;
            index_o   <= '0;
            is_xop_o  <= 1'b0;
            is_call_o <= 1'b0;
            trap_en_o <= 1'b0;
        end else begin
            take_o <= do_take;
            if (do_take) begin
                vector_o  <= addr;
                index_o   <= pick.code;
                is_xop_o  <= pick.is_xop;
                is_call_o <= is_call;
            end
            if (do_take && quiets_en) begin
                trap_en_o <= 1'b0;
            end else if (en_wr) begin
                trap_en_o <= en_wdata;
            end
        end
    end
endmodule

// File: rtl/trapvec_ctrl_chk.sv
module trapvec_ctrl_chk
    import trapvec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              take_o,
    input logic [ADDR_W-1:0] vector_o,
    input logic [OP_W-1:0]   index_o,
    input logic              is_xop_o,
    input logic              is_call_o,
    input logic              trap_en_o
);
    assert_take_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    assert_reset_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !is_xop_o && index_o == OP_W'(RESET_IDX)) |-> !is_call_o);

    assert_other_call_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && (is_xop_o || index_o != OP_W'(RESET_IDX))) |-> is_call_o);

    assert_quad0_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !is_xop_o && index_o < OP_W'(QUAD_SIZE)) |-> !trap_en_o);

    assert_mask_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !is_xop_o && index_o >= OP_W'(MASK_LO) && index_o <= OP_W'(MASK_HI))
        |-> $past(trap_en_o));

    assert_index_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !is_xop_o) |-> index_o < OP_W'(NUM_TRAPS));

    assert_trap_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !is_xop_o) |-> vector_o == ADDR_W'(32'h40400) + ADDR_W'(index_o) * 4);

    assert_xop_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && is_xop_o) |-> vector_o == ADDR_W'(32'h40000) + ADDR_W'(index_o) * 4);
endmodule

bind trapvec_ctrl trapvec_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_o   (take_o),
    .vector_o (vector_o),
    .index_o  (index_o),
    .is_xop_o (is_xop_o),
    .is_call_o(is_call_o),
    .trap_en_o(trap_en_o)
);

// File: tb/trapvec_ctrl_bench.sv
`timescale 1ns/1ps
module trapvec_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] trap_req = '0;
    logic        reset_req = 1'b0;
    logic        xop_req = 1'b0;
    logic [7:0]  xop_op = '0;
    logic        en_wr = 1'b0;
    logic        en_wdata = 1'b0;
    logic        take_o;
    logic [31:0] vector_o;
    logic [7:0]  index_o;
    logic        is_xop_o;
    logic        is_call_o;
    logic        trap_en_o;

    trapvec_ctrl u_trapvec_ctrl (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .reset_req(reset_req),
        .xop_req(xop_req), .xop_op(xop_op), .en_wr(en_wr), .en_wdata(en_wdata),
        .take_o(take_o), .vector_o(vector_o), .index_o(index_o),
        .is_xop_o(is_xop_o), .is_call_o(is_call_o), .trap_en_o(trap_en_o)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference model
    bit      m_pend [48];
    bit      m_x;
    int      m_xcode;
    bit      m_en;
    bit      m_busy;
    bit      m_take;
    int      m_idx;
    bit      m_isx;
    bit      m_call;
    longint  m_vec;
    int      m_sel;
    bit      m_selx;
    bit      m_q0;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_pend[i]) m_pend[i] = 0;
            m_x = 0; m_xcode = 0; m_en = 0; m_busy = 0; m_take = 0;
            m_idx = 0; m_isx = 0; m_call = 0; m_vec = 0;
        end else begin
            m_sel = -1; m_selx = 0; m_q0 = 0;
            if (!m_busy) begin
                if (m_pend[7]) m_sel = 7;
                else begin
                    for (int i = 0; i < 48; i++)
                        if (m_sel < 0 && m_pend[i] && !(i >= 8 && i <= 15 && !m_en)) m_sel = i;
                end
                if (m_sel < 0 && m_x) m_selx = 1;
            end
            m_take = (m_sel >= 0) || m_selx;
            m_busy = m_take;
            if (m_sel >= 0) begin
                m_idx = m_sel; m_isx = 0; m_call = (m_sel != 7);
                m_vec = 32'o1000000 + 1024 + 4 * m_sel;
                m_pend[m_sel] = 0;
                if (m_sel < 16) m_q0 = 1;
            end else if (m_selx) begin
                m_idx = m_xcode; m_isx = 1; m_call = 1;
                m_vec = 32'o1000000 + 4 * m_xcode;
                m_x = 0;
            end
            if (m_q0) m_en = 0;
            else if (en_wr) m_en = en_wdata;
            for (int i = 0; i < 48; i++) if (trap_req[i]) m_pend[i] = 1;
            if (reset_req) m_pend[7] = 1;
            if (xop_req && !m_x) begin
                m_x = 1; m_xcode = int'(xop_op);
            end
        end
    end

    int log_idx[$];
    int log_isx[$];
    int log_call[$];
    longint log_vec[$];

    always begin
        @(posedge clk);
        #1;
        if (rst_n && !done) begin
            chk(take_o == m_take, "R8 take strobe", take_o, m_take);
            chk(trap_en_o == m_en, "R6 R9 enable bit", trap_en_o, m_en);
            if (take_o && m_take) begin
                chk(int'(index_o) == m_idx, "R4 choice", index_o, m_idx);
                chk(is_xop_o == m_isx, "R3 xop flag", is_xop_o, m_isx);
                chk(is_call_o == m_call, "R7 call flag", is_call_o, m_call);
                chk(longint'(vector_o) == m_vec, "R2 vector", vector_o, m_vec);
            end
            if (take_o) begin
                log_idx.push_back(int'(index_o));
                log_isx.push_back(int'(is_xop_o));
                log_call.push_back(int'(is_call_o));
                log_vec.push_back(longint'(vector_o));
            end
        end
    end

    task automatic clear_log();
        log_idx.delete(); log_isx.delete(); log_call.delete(); log_vec.delete();
    endtask

    task automatic write_en(input bit v);
        @(negedge clk); en_wr = 1; en_wdata = v;
        @(negedge clk); en_wr = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(take_o == 0 && trap_en_o == 0 && vector_o == 0 && index_o == 0, "R1 in reset",
            {take_o, trap_en_o, vector_o}, 0);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        chk(take_o == 0 && trap_en_o == 0 && is_call_o == 0 && is_xop_o == 0, "R1 after release",
            {take_o, trap_en_o, is_call_o, is_xop_o}, 0);

        // R5: maskable index held while disabled
        @(negedge clk); trap_req[9] = 1;
        @(negedge clk); trap_req = '0;
        repeat (5) @(negedge clk);
        chk(log_idx.size() == 0, "R5 masked not served", log_idx.size(), 0);
        write_en(1);
        repeat (4) @(negedge clk);
        chk(log_idx.size() == 1 && log_idx[0] == 9, "R5 served after enable", log_idx.size() ? log_idx[0] : -1, 9);
        chk(log_vec.size() == 1 && log_vec[0] == 64'h40424, "R2 vector idx 9", log_vec.size() ? log_vec[0] : -1, 64'h40424);
        chk(trap_en_o == 0, "R6 quad0 clears enable", trap_en_o, 0);
        clear_log();

        // R6: mode-fault index 31 leaves enable set
        write_en(1);
        @(negedge clk); trap_req[31] = 1;
        @(negedge clk); trap_req = '0;
        repeat (4) @(negedge clk);
        chk(log_idx.size() == 1 && log_vec[0] == 64'h4047C, "R2 vector idx 31", log_vec.size() ? log_vec[0] : -1, 64'h4047C);
        chk(trap_en_o == 1, "R6 upper index keeps enable", trap_en_o, 1);
        clear_log();

        // R4 R7 R3: reset, two traps and an Xop together
        @(negedge clk); trap_req[20] = 1; trap_req[33] = 1; reset_req = 1; xop_req = 1; xop_op = 8'd5;
        @(negedge clk); trap_req = '0; reset_req = 0; xop_req = 0;
        repeat (12) @(negedge clk);
        chk(log_idx.size() == 4, "R4 count", log_idx.size(), 4);
        if (log_idx.size() == 4) begin
            chk(log_idx[0] == 7 && log_idx[1] == 20 && log_idx[2] == 33, "R4 order",
                log_idx[0] * 65536 + log_idx[1] * 256 + log_idx[2], 7 * 65536 + 20 * 256 + 33);
            chk(log_call[0] == 0 && log_call[1] == 1, "R7 reset is jump", log_call[0], 0);
            chk(log_isx[3] == 1 && log_idx[3] == 5 && log_vec[3] == 64'h40014, "R3 xop vector", log_vec[3], 64'h40014);
        end
        clear_log();

        // R11: reset via trap line 7
        @(negedge clk); trap_req[7] = 1; trap_req[2] = 1;
        @(negedge clk); trap_req = '0;
        repeat (6) @(negedge clk);
        chk(log_idx.size() == 2 && log_idx[0] == 7 && log_call[0] == 0, "R11 line 7 is reset",
            log_idx.size() ? log_idx[0] : -1, 7);
        clear_log();

        // R10: second Xop while first pending is dropped
        @(negedge clk); trap_req[40] = 1; xop_req = 1; xop_op = 8'h10;
        @(negedge clk); trap_req = '0; xop_op = 8'h22;
        @(negedge clk); xop_req = 0;
        repeat (8) @(negedge clk);
        chk(log_idx.size() == 2, "R10 count", log_idx.size(), 2);
        if (log_idx.size() == 2)
            chk(log_isx[1] == 1 && log_idx[1] == 8'h10, "R10 first opcode kept", log_idx[1], 8'h10);
        clear_log();

        // R5: maskable stays pending while others pass
        @(negedge clk); trap_req[12] = 1; trap_req[40] = 1;
        @(negedge clk); trap_req = '0;
        repeat (6) @(negedge clk);
        chk(log_idx.size() == 1 && log_idx[0] == 40, "R5 nonmaskable passes", log_idx.size() ? log_idx[0] : -1, 40);
        write_en(1);
        repeat (4) @(negedge clk);
        chk(log_idx.size() == 2 && log_idx[1] == 12, "R5 held index served", log_idx.size() > 1 ? log_idx[1] : -1, 12);
        clear_log();

        // R9: plain write, then write colliding with a quad0 take
        write_en(1);
        chk(trap_en_o == 1, "R9 write sets bit", trap_en_o, 1);
        @(negedge clk); trap_req[2] = 1;
        @(negedge clk); trap_req = '0; en_wr = 1; en_wdata = 1;
        @(negedge clk); en_wr = 0;
        chk(trap_en_o == 0, "R9 clear wins", trap_en_o, 0);
        repeat (4) @(negedge clk);
        clear_log();

        // R8: request re-raised at its own take edge stays pending
        @(negedge clk); trap_req[25] = 1;
        @(negedge clk);
        @(negedge clk); trap_req = '0;
        repeat (6) @(negedge clk);
        chk(log_idx.size() == 2, "R8 re-raised served twice", log_idx.size(), 2);
        clear_log();

        // mixed random traffic against the model
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            trap_req  = {16'($urandom & $urandom & $urandom & $urandom),
                         $urandom & $urandom & $urandom & $urandom & $urandom};
            reset_req = ($urandom % 24) == 0;
            xop_req   = ($urandom % 4) == 0;
            xop_op    = 8'($urandom);
            en_wr     = ($urandom % 6) == 0;
            en_wdata  = 1'($urandom);
        end
        @(negedge clk); trap_req = '0; reset_req = 0; xop_req = 0; en_wr = 0;
        repeat (150) @(negedge clk);
        finish_run();
    end
endmodule